// File: doc/BRIEF.md
# Pixel Hit Time-Stamp Capture Cell

This cell sits in every pixel of a hybrid detector readout matrix. It watches the pixel's binary discriminator output and a Gray-coded time-stamp bus that all pixels share. The bus advances once per 40 MHz tick. When the hit goes high, the cell stores the bus value as the arrival stamp. When the hit goes low, it stores the bus value as the departure stamp and raises a read request toward the column readout controller.

After that the cell is frozen. Further discriminator edges cannot touch the stored stamps until the controller selects the cell with its read strobe and then drops that strobe. The two stamps and a fixed row address together form the readout word. A hit that has begun but not ended keeps the cell waiting without a request. The hit input is taken as already synchronous to the cell clock.

Top module: `pix_stamp_cell`

## Requirements
- R1: After reset `req_o` is 0, both stamp outputs are 0 and `row_o` equals the parameter `ROW_ID`.
- R2: In the idle state, the first cycle in which `hit_i` is sampled 1 after being sampled 0 stores the `ts_gray_i` value of that cycle into `le_ts_o`. The value is visible from the following cycle, and `te_ts_o` does not change.
- R3: After a stored leading edge, the first cycle in which `hit_i` is sampled 0 stores that cycle's `ts_gray_i` into `te_ts_o` and sets `req_o`. Both are visible from the following cycle.
- R4: While the hit stays high after its leading edge, `req_o` stays 0 and `le_ts_o` keeps its value, however long the hit lasts.
- R5: While a request is pending or being read, rising and falling edges of `hit_i` change neither stamp and do not clear `req_o`.
- R6: A pending request is selected by `rd_sel_i` = 1. The first later cycle with `rd_sel_i` = 0 returns the cell to idle and clears `req_o` from the next cycle on. The stamp outputs keep their values.
- R7: `rd_sel_i` has no effect when no request is set, whether the cell is idle or a hit is in progress. `req_o` stays 0 and a later hit is captured normally.
- R8: A rising hit edge that falls in the same cycle as the release is not captured. While that hit stays high, and when it later falls, the stamps stay unchanged and no request is raised.
- R9: A hit that is high for exactly one cycle gives a leading stamp and a trailing stamp taken on consecutive cycles.
- R10: `row_o` always equals `ROW_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 40 MHz cell clock |
| rst | input | 1 | Synchronous active-high reset |
| hit_i | input | 1 | Discriminator output, synchronous to clk |
| ts_gray_i | input | TS_W | Shared Gray-coded time-stamp bus |
| rd_sel_i | input | 1 | Read strobe from the readout controller |
| req_o | output | 1 | Read request, set at the trailing edge |
| le_ts_o | output | TS_W | Stored leading-edge stamp |
| te_ts_o | output | TS_W | Stored trailing-edge stamp |
| row_o | output | ROW_W | Pixel row address |

## Verification
Two events can fall in the same cycle: the release, when the read strobe drops, and a fresh rising hit edge. The bench provokes this in every other trial of its sweep. It raises `hit_i` in exactly the cycle in which `rd_sel_i` goes low. It then expects `req_o` to clear, the stamps to stay as they were, and neither the held-high hit nor its later fall to cause a capture or a request. The sweep also covers hit widths from one to five cycles, edges while a request is pending, strobes outside a request, and stamp values that wrap around the full bus range.

// File: rtl/pix_pkg.sv
package pix_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PEND  = 2'd2,
    ST_READ  = 2'd3
  } cell_st_t;

  localparam int unsigned STAMP_LE = 0;
  localparam int unsigned STAMP_TE = 1;
  localparam int unsigned STAMP_N  = 2;

endpackage

// File: rtl/pix_edge_det.sv
module pix_edge_det (
  input  logic clk,
  input  logic rst,
  input  logic lvl_i,
  output logic rise_o,
  output logic fall_o
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_i;
  end

  assign rise_o = lvl_i & ~lvl_q;
  assign fall_o = ~lvl_i & lvl_q;

endmodule

// File: rtl/pix_stamp_reg.sv
module pix_stamp_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  always_ff @(posedge clk) begin
    if (rst)         q_o <= '0;
    else if (load_i) q_o <= d_i;
  end

endmodule

// File: rtl/pix_cell_fsm.sv
module pix_cell_fsm
  import pix_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     rise_i,
  input  logic     fall_i,
  input  logic     rd_sel_i,
  output logic     load_le_o,
  output logic     load_te_o,
  output logic     req_o,
  output cell_st_t state_o
);

  cell_st_t state_q, state_d;
  logic     req_q, req_d;

  always_comb begin
    state_d   = state_q;
    req_d     = req_q;
    load_le_o = 1'b0;
    load_te_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (rise_i) begin
          load_le_o = 1'b1;
          state_d   = ST_ARMED;
        end
      end
      ST_ARMED: begin
        if (fall_i) begin
          load_te_o = 1'b1;
          req_d     = 1'b1;
          state_d   = ST_PEND;
        end
      end
      ST_PEND: begin
        if (rd_sel_i) state_d = ST_READ;
      end
      ST_READ: begin
        if (!rd_sel_i) begin
          req_d   = 1'b0;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      req_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      req_q   <= req_d;
    end
  end

  assign req_o   = req_q;
  assign state_o = state_q;

  AST_REQ_FROM_FALL: assert property (@(posedge clk) disable iff (rst)
    $rose(req_q) |-> $past(fall_i)); // R3

  AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE || state_q == ST_ARMED) |-> !req_q); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_PEND) |=> req_q); // R5

  AST_REQ_DROP: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_READ && !rd_sel_i) |=> !req_q); // R6

endmodule

// File: rtl/pix_stamp_cell.sv
module pix_stamp_cell
  import pix_pkg::*;
#(
  parameter int unsigned TS_W   = 8,
  parameter int unsigned ROW_W  = 5,
  parameter logic [ROW_W-1:0] ROW_ID = 5'd19
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hit_i,
  input  logic [TS_W-1:0]  ts_gray_i,
  input  logic             rd_sel_i,
  output logic             req_o,
  output logic [TS_W-1:0]  le_ts_o,
  output logic [TS_W-1:0]  te_ts_o,
  output logic [ROW_W-1:0] row_o
);

  logic                rise, fall;
  logic                load_le, load_te;
  cell_st_t            state;
  logic [STAMP_N-1:0]  load_vec;
  logic [TS_W-1:0]     stamp_q [STAMP_N];

  pix_edge_det u_edge (
    .clk    (clk),
    .rst    (rst),
    .lvl_i  (hit_i),
    .rise_o (rise),
    .fall_o (fall)
  );

  pix_cell_fsm u_fsm (
    .clk       (clk),
    .rst       (rst),
    .rise_i    (rise),
    .fall_i    (fall),
    .rd_sel_i  (rd_sel_i),
    .load_le_o (load_le),
    .load_te_o (load_te),
    .req_o     (req_o),
    .state_o   (state)
  );

  assign load_vec[STAMP_LE] = load_le;
  assign load_vec[STAMP_TE] = load_te;

  for (genvar g = 0; g < STAMP_N; g++) begin : g_stamp
    pix_stamp_reg #(.W(TS_W)) u_reg (
      .clk    (clk),
      .rst    (rst),
      .load_i (load_vec[g]),
      .d_i    (ts_gray_i),
      .q_o    (stamp_q[g])
    );
  end

  assign le_ts_o = stamp_q[STAMP_LE];
  assign te_ts_o = stamp_q[STAMP_TE];
  assign row_o   = ROW_ID;

  AST_LE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && rise) |=> (le_ts_o == $past(ts_gray_i))); // R2

  AST_TE_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_ARMED && fall) |=> (te_ts_o == $past(ts_gray_i) && req_o)); // R3

  AST_LE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |=> $stable(le_ts_o)); // R5

  AST_TE_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PEND || state == ST_READ) |=> $stable(te_ts_o)); // R5

endmodule

// File: tb/pix_stamp_cell_test.sv
module pix_stamp_cell_test;

  localparam int unsigned TS_W  = 8;
  localparam int unsigned ROW_W = 5;
  localparam logic [ROW_W-1:0] ROW_ID = 5'd19;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             hit_i = 1'b0;
  logic [TS_W-1:0]  ts_gray_i = '0;
  logic             rd_sel_i = 1'b0;
  logic             req_o;
  logic [TS_W-1:0]  le_ts_o, te_ts_o;
  logic [ROW_W-1:0] row_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit done   = 1'b0;
  logic [TS_W-1:0] cnt = '0;
  logic [TS_W-1:0] exp_le = '0, exp_te = '0;
  logic [TS_W-1:0] last_ts;

  always #10 clk = ~clk;
  always @(posedge clk) cycles++;

  pix_stamp_cell #(.TS_W(TS_W), .ROW_W(ROW_W), .ROW_ID(ROW_ID)) uut (
    .clk(clk), .rst(rst), .hit_i(hit_i), .ts_gray_i(ts_gray_i),
    .rd_sel_i(rd_sel_i), .req_o(req_o), .le_ts_o(le_ts_o),
    .te_ts_o(te_ts_o), .row_o(row_o)
  );

  function automatic logic [TS_W-1:0] gray(input logic [TS_W-1:0] b);
    return b ^ (b >> 1);
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Called at a negedge: drive, let one posedge pass, return at next negedge.
  task automatic cyc(input logic h, input logic s);
    hit_i     = h;
    rd_sel_i  = s;
    ts_gray_i = gray(cnt);
    last_ts   = gray(cnt);
    @(negedge clk);
    cnt = cnt + 1'b1;
  endtask

  task automatic chk_state(input string tag, input logic exp_req);
    chk(req_o == exp_req, {tag, " req"}, 32'(req_o), 32'(exp_req));
    chk(le_ts_o == exp_le, {tag, " le"}, 32'(le_ts_o), 32'(exp_le));
    chk(te_ts_o == exp_te, {tag, " te"}, 32'(te_ts_o), 32'(exp_te));
  endtask

  initial begin : watchdog
    while (cycles < 100000 && !done) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk_state("R1 reset", 1'b0);
    chk(row_o == ROW_ID, "R1 row", 32'(row_o), 32'(ROW_ID));

    for (int t = 0; t < 300; t++) begin
      int  w    = 1 + (t % 5);
      int  gap  = t % 3;
      int  hold = 1 + (t % 2);
      bit  rh   = (t % 2) == 1;
      bit  isel = (t % 4) == 0;
      bit  asel = (t % 3) == 1;

      cyc(1'b0, isel);
      chk_state("R7 idle strobe", 1'b0);
      cyc(1'b0, 1'b0);

      // leading edge
      cyc(1'b1, 1'b0);
      exp_le = last_ts;
      chk_state("R2 lead capture", 1'b0);

      for (int k = 1; k < w; k++) begin
        cyc(1'b1, asel && (k == 1));
        chk_state(asel ? "R7 armed strobe" : "R4 hit held", 1'b0);
      end

      // trailing edge
      cyc(1'b0, 1'b0);
      exp_te = last_ts;
      chk_state(w == 1 ? "R9 one-cycle hit" : "R3 trail capture", 1'b1);

      for (int k = 0; k < gap; k++) begin
        cyc(k % 2 == 0, 1'b0);
        chk_state("R5 edge while pending", 1'b1);
      end
      if (gap == 1) begin
        cyc(1'b0, 1'b0);
        chk_state("R5 fall while pending", 1'b1);
      end

      for (int k = 0; k < hold; k++) begin
        cyc(1'b0, 1'b1);
        chk_state("R5 selected", 1'b1);
      end

      // release, possibly together with a rising hit
      cyc(rh, 1'b0);
      chk_state(rh ? "R8 release with rise" : "R6 release", 1'b0);

      if (rh) begin
        cyc(1'b1, 1'b0);
        chk_state("R8 held hit ignored", 1'b0);
        cyc(1'b0, 1'b0);
        chk_state("R8 fall ignored", 1'b0);
      end
      chk(row_o == ROW_ID, "R10 row", 32'(row_o), 32'(ROW_ID));
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule